// File: doc/BRIEF.md
# Per-Pin GPIO Controller with Interrupt Detection

This block controls a parameterised set of general-purpose pins (64 by default) through one 32-bit control word per pin on a simple memory-mapped read/write bus. Each word carries the pin's output latch, output enable, interrupt enable, a three-bit trigger code, an input-freeze flag, a flag that preserves the pin's drive state across a soft reset, a write-1-to-clear event flag and the synchronised pad level.

Pads pass through a two-stage synchroniser. Edge and level conditions are then decoded from the current and previous samples. A detected condition latches the pin's event flag. Read-only summary words gather the event flags of 32 pins each, so software can scan a whole bank in one read. A single interrupt line is raised when any latched event also has its enable bit set. The bus read path is combinational: read data is valid in the same cycle as the address.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After `rst_n` is released, every control word and every summary word reads 0, `pad_oe` and `pad_out` are all low, and `irq_out` is low.
- R2: Pin n's control word is at byte address 0x180 + 4*n. Writable fields are: bit 0 output latch, bit 1 output enable (1 = drive), bit 2 interrupt enable, bits 5:3 trigger code, bit 6 keep-on-soft-reset and bit 9 input freeze. They read back as written. Bit 0 reads the latch, not the pad. `pad_out[n]` and `pad_oe[n]` follow bits 0 and 1.
- R3: Bit 13 of pin n's word shows `pad_in[n]` after two rising clock edges, whether the pin is an input or an output. It cannot be written.
- R4: Edge trigger codes (bits 5:3) are 000 for falling, 001 for rising and 101 for both edges. A qualifying pad change sets the event flag (bit 12) on the third rising edge after the change.
- R5: Level trigger codes are 010 for low and 011 for high. While the active level persists, the event flag sets again in the cycle after it is cleared. Codes 100, 110 and 111 never set the flag.
- R6: Writing 1 to bit 12 clears the event flag, and writing 0 there leaves it unchanged. If a new detection falls in the same cycle as the clearing write, the flag stays set.
- R7: The summary word for bank b is at 0x100 + 4*b. Its bit p equals the event flag of pin 32*b + p. Writes to summary addresses change nothing.
- R8: While bit 9 is set, the bit 13 sample of that pin is frozen and no new event is latched. An event already latched is kept.
- R9: `irq_out` is high exactly when at least one pin has both its event flag and its interrupt enable set. Event flags latch whether or not the enable is set.
- R10: A one-cycle `soft_rst` clears every field and event flag. The exception is pins with bit 6 set, which keep bits 0, 1 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| soft_rst | input | 1 | Synchronous soft reset honouring the keep flag |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | NUM_PINS (64) | Pad levels, asynchronous |
| pad_out | output | NUM_PINS (64) | Output latch per pin |
| pad_oe | output | NUM_PINS (64) | Output enable per pin |
| irq_out | output | 1 | Combined interrupt |

## Verification
The collision that matters here is a write-1-to-clear landing on the same clock edge where the detector latches a new event for that pin. The bench provokes it by raising a rising-edge pin's pad and counting edges so that the clearing write commits on the third edge, which is the detection edge. It then judges that the flag still reads 1, and that a later clear with no new event does bring it to 0. Level re-assertion after a clear is exercised in the same way. A level trigger must win against the clear on every cycle in which the active level is still present.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

   localparam int unsigned WORD_W     = 32;
   localparam int unsigned BANK_PINS  = 32;
   localparam int unsigned SUM_BASE   = 'h100;
   localparam int unsigned CTRL_BASE  = 'h180;

   localparam int unsigned B_OUT  = 0;
   localparam int unsigned B_DIR  = 1;
   localparam int unsigned B_IEN  = 2;
   localparam int unsigned B_TYP  = 3;
   localparam int unsigned B_KEEP = 6;
   localparam int unsigned B_FRZ  = 9;
   localparam int unsigned B_EVT  = 12;
   localparam int unsigned B_LVL  = 13;

   typedef enum logic [2:0] {
      TRIG_FALL = 3'b000,
      TRIG_RISE = 3'b001,
      TRIG_LOW  = 3'b010,
      TRIG_HIGH = 3'b011,
      TRIG_BOTH = 3'b101
   } trig_e;

   typedef struct packed {
      logic       out;
      logic       dir;
      logic       ien;
      logic [2:0] typ;
      logic       keep;
      logic       frz;
      logic       clr;
   } wr_fields_t;

   function automatic logic trig_hit(input logic [2:0] t, input logic cur, input logic prv);
      case (t)
         TRIG_FALL: return prv & ~cur;
         TRIG_RISE: return ~prv & cur;
         TRIG_BOTH: return prv ^ cur;
         TRIG_LOW:  return ~cur;
         TRIG_HIGH: return cur;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic hold,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES) - 1; i++) begin
            chain[i] <= chain[i-1];
         end
         if (!hold) begin
            chain[STAGES-1] <= chain[STAGES-2];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_pin_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  wr_fields_t        wf,
   input  logic              pad_i,
   output logic [WORD_W-1:0] ctrl_o,
   output logic              evt_o,
   output logic              ien_o,
   output logic              frz_o,
   output logic              lvl_o,
   output logic              out_o,
   output logic              oe_o
);
   logic       out_q, dir_q, ien_q, keep_q, frz_q, evt_q;
   logic [2:0] typ_q;
   logic       samp, prev_q, hit;

   gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_i),
      .hold (frz_q),
      .q    (samp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= samp;
   end

   assign hit = trig_hit(typ_q, samp, prev_q) & ~frz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0; dir_q <= 1'b0; ien_q <= 1'b0; typ_q <= '0;
         keep_q <= 1'b0; frz_q <= 1'b0; evt_q <= 1'b0;
      end else if (soft_rst) begin
         if (!keep_q) begin
            out_q  <= 1'b0;
            dir_q  <= 1'b0;
            keep_q <= 1'b0;
         end
         ien_q <= 1'b0; typ_q <= '0; frz_q <= 1'b0; evt_q <= 1'b0;
      end else begin
         if (wr_en) begin
            out_q  <= wf.out;
            dir_q  <= wf.dir;
            ien_q  <= wf.ien;
            typ_q  <= wf.typ;
            keep_q <= wf.keep;
            frz_q  <= wf.frz;
         end
         if (hit)                     evt_q <= 1'b1;
         else if (wr_en && wf.clr)    evt_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_o             = '0;
      ctrl_o[B_OUT]      = out_q;
      ctrl_o[B_DIR]      = dir_q;
      ctrl_o[B_IEN]      = ien_q;
      ctrl_o[B_TYP +: 3] = typ_q;
      ctrl_o[B_KEEP]     = keep_q;
      ctrl_o[B_FRZ]      = frz_q;
      ctrl_o[B_EVT]      = evt_q;
      ctrl_o[B_LVL]      = samp;
   end

   assign evt_o = evt_q;
   assign ien_o = ien_q;
   assign frz_o = frz_q;
   assign lvl_o = samp;
   assign out_o = out_q;
   assign oe_o  = dir_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
   import gpio_pin_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 64,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq_out
);
   localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;
   localparam int unsigned PAD_W     = NUM_BANKS * BANK_PINS;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 1024) begin : g_bad_pins
         $error("gpio_pin_ctrl: NUM_PINS must be 1..1024");
      end
      if (CTRL_BASE + 4 * NUM_PINS > (64'd1 << ADDR_W)) begin : g_bad_addr
         $error("gpio_pin_ctrl: ADDR_W too narrow for NUM_PINS");
      end
   endgenerate

   logic                wr_any;
   wr_fields_t          wf;
   logic                unused_wbits;
   logic [WORD_W-1:0]   ctrl_w [NUM_PINS];
   logic [NUM_PINS-1:0] evt_vec, ien_vec, frz_vec, lvl_vec;
   logic [PAD_W-1:0]    evt_pad;

   assign wr_any = bus_sel & bus_wr;

   assign wf.out  = bus_wdata[B_OUT];
   assign wf.dir  = bus_wdata[B_DIR];
   assign wf.ien  = bus_wdata[B_IEN];
   assign wf.typ  = bus_wdata[B_TYP +: 3];
   assign wf.keep = bus_wdata[B_KEEP];
   assign wf.frz  = bus_wdata[B_FRZ];
   assign wf.clr  = bus_wdata[B_EVT];
   assign unused_wbits = ^{bus_wdata[WORD_W-1:B_LVL], bus_wdata[11:10], bus_wdata[8:7]};

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_BASE + 4 * n);
      logic hit_wr;
      assign hit_wr = wr_any && (bus_addr == MY_ADDR);

      gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .soft_rst(soft_rst),
         .wr_en   (hit_wr),
         .wf      (wf),
         .pad_i   (pad_in[n]),
         .ctrl_o  (ctrl_w[n]),
         .evt_o   (evt_vec[n]),
         .ien_o   (ien_vec[n]),
         .frz_o   (frz_vec[n]),
         .lvl_o   (lvl_vec[n]),
         .out_o   (pad_out[n]),
         .oe_o    (pad_oe[n])
      );
   end

   generate
      if (PAD_W > NUM_PINS) begin : g_pad
         assign evt_pad = {{(PAD_W - NUM_PINS){1'b0}}, evt_vec};
      end else begin : g_nopad
         assign evt_pad = evt_vec;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < int'(NUM_PINS); i++) begin
         if (bus_addr == ADDR_W'(CTRL_BASE + 4 * i)) bus_rdata = ctrl_w[i];
      end
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
         if (bus_addr == ADDR_W'(SUM_BASE + 4 * b)) bus_rdata = evt_pad[b*BANK_PINS +: BANK_PINS];
      end
   end

   assign irq_out = |(evt_vec & ien_vec);
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk #(
   parameter int unsigned NUM_PINS = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                soft_rst,
   input logic                wr_any,
   input logic                irq_out,
   input logic [NUM_PINS-1:0] evt_vec,
   input logic [NUM_PINS-1:0] frz_vec,
   input logic [NUM_PINS-1:0] lvl_vec
);
   p_evt_drop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt_vec) & ~evt_vec) != '0) |-> $past(wr_any || soft_rst));

   p_frozen_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((lvl_vec ^ $past(lvl_vec)) & $past(frz_vec)) == '0);

   p_frozen_no_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vec & ~$past(evt_vec) & $past(frz_vec)) == '0);

   p_soft_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_rst) |-> (evt_vec == '0 && !irq_out));

   p_irq_needs_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (evt_vec != '0));
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .soft_rst(soft_rst),
   .wr_any  (wr_any),
   .irq_out (irq_out),
   .evt_vec (evt_vec),
   .frz_vec (frz_vec),
   .lvl_vec (lvl_vec)
);

// File: tb/sim_gpio_pin_ctrl.sv
module sim_gpio_pin_ctrl;
   localparam int NP = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe;
   logic          irq_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   gpio_pin_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
   );

   // {trigger code[2:0], pad before, pad after, expected event}
   localparam logic [5:0] VEC [14] = '{
      6'b000_10_1, 6'b000_01_0, 6'b001_01_1, 6'b001_10_0,
      6'b101_01_1, 6'b101_10_1, 6'b101_11_0, 6'b010_10_1,
      6'b010_11_0, 6'b011_01_1, 6'b011_00_0, 6'b100_01_0,
      6'b110_10_0, 6'b111_01_0
   };

   function automatic logic [11:0] pa(input int n);
      return 12'(32'h180 + 4 * n);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(pa(0), d);      chk("R1 ctrl pin0", d, 32'h0);
      rd(pa(63), d);     chk("R1 ctrl pin63", d, 32'h0);
      rd(12'h100, d);    chk("R1 summary bank0", d, 32'h0);
      chk("R1 pad_oe", 32'(pad_oe != '0), 32'h0);
      chk("R1 irq", 32'(irq_out), 32'h0);

      // R2 field readback, latch vs pad
      wr(pa(3), 32'h27F);
      rd(pa(3), d);      chk("R2 readback pin3", d, 32'h27F);
      chk("R2 pad_out pin3", 32'(pad_out[3]), 32'h1);
      chk("R2 pad_oe pin3", 32'(pad_oe[3]), 32'h1);

      // R3 input sample after two edges, pin is an output
      wr(pa(7), 32'h2);
      pad_in[7] = 1'b1;
      rd(pa(7), d);      chk("R3 level after 1 edge", 32'(d[13]), 32'h0);
      rd(pa(7), d);      chk("R3 level after 2 edges", 32'(d[13]), 32'h1);
      wr(pa(7), 32'h2002);
      rd(pa(7), d);      chk("R3 level bit not writable", 32'(d[13]), 32'h1);

      // R4 / R5 trigger code table on pin 5
      for (int i = 0; i < 14; i++) begin
         logic [31:0] cw;
         cw = {26'b0, VEC[i][5:3], 3'b000};
         pad_in[5] = VEC[i][2];
         wr(pa(5), cw);
         idle(4);
         wr(pa(5), cw | 32'h1000);
         pad_in[5] = VEC[i][1];
         idle(4);
         rd(pa(5), d);
         chk($sformatf("R4/R5 trigger vector %0d", i), 32'(d[12]), 32'(VEC[i][0]));
      end

      // R6 clear behaviour and collision with detection
      wr(pa(9), 32'h0C);
      pad_in[9] = 1'b1;
      idle(4);
      rd(pa(9), d);      chk("R6 rise latched", 32'(d[12]), 32'h1);
      wr(pa(9), 32'h0C);
      rd(pa(9), d);      chk("R6 write 0 keeps", 32'(d[12]), 32'h1);
      pad_in[9] = 1'b0;
      idle(4);
      pad_in[9] = 1'b1;
      @(negedge clk);
      wr(pa(9), 32'h100C);
      rd(pa(9), d);      chk("R6 detect wins over clear", 32'(d[12]), 32'h1);
      wr(pa(9), 32'h100C);
      rd(pa(9), d);      chk("R6 clear with no event", 32'(d[12]), 32'h0);

      // R5 level re-assertion
      wr(pa(11), 32'h1C);
      pad_in[11] = 1'b1;
      idle(4);
      wr(pa(11), 32'h101C);
      rd(pa(11), d);     chk("R5 high level re-asserts", 32'(d[12]), 32'h1);
      pad_in[11] = 1'b0;
      idle(4);
      wr(pa(11), 32'h101C);
      rd(pa(11), d);     chk("R5 cleared once level gone", 32'(d[12]), 32'h0);

      // R8 freeze
      wr(pa(12), 32'h20C);
      idle(2);
      pad_in[12] = 1'b1;
      idle(4);
      rd(pa(12), d);     chk("R8 frozen level and no event", d, 32'h20C);

      // R10 soft reset with keep flag
      wr(pa(20), 32'h43);
      wr(pa(21), 32'h03);
      pad_in = '0;
      idle(5);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      idle(2);
      rd(pa(20), d);     chk("R10 kept pin20", d, 32'h43);
      rd(pa(21), d);     chk("R10 cleared pin21", d, 32'h0);
      chk("R10 pad_oe kept", 32'(pad_oe[20]), 32'h1);
      chk("R10 pad_oe cleared", 32'(pad_oe[21]), 32'h0);
      rd(12'h100, d);    chk("R10 events cleared", d, 32'h0);

      // R7 / R9 summary and interrupt on pin 40 (bank 1 bit 8)
      wr(pa(40), 32'h08);
      pad_in[40] = 1'b1;
      idle(4);
      rd(12'h104, d);    chk("R7 bank1 bit8", d, 32'h100);
      rd(12'h100, d);    chk("R7 bank0 empty", d, 32'h0);
      chk("R9 no irq without enable", 32'(irq_out), 32'h0);
      wr(12'h104, 32'hFFFF_FFFF);
      rd(12'h104, d);    chk("R7 summary write ignored", d, 32'h100);
      wr(pa(40), 32'h0C);
      #1 chk("R9 irq with enable", 32'(irq_out), 32'h1);
      wr(pa(40), 32'h100C);
      #1 chk("R9 irq drops after clear", 32'(irq_out), 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule